// File: doc/BRIEF.md
# Pixel Clock Configuration Register Bank

This block is a byte-wide control register file for a line-locked pixel clock generator. A serial-bus slave front end drives it through one-cycle write and read strobes with an address and a data byte. The bank holds a fixed revision byte, a 12-bit feedback divide ratio, a VCO band field, a charge-pump current code and an external clock select. It presents the active settings to the clock logic as plain outputs.

The divide ratio is double-buffered. The upper eight bits are staged at one address. The lower four bits are written at a second address, and that write commits the staged upper byte and the new low nibble together as one 12-bit value. A commit of 0 or 1 is refused and flagged, and the previous active value stays. The VCO band field is decoded in the bank into a post-divide factor. When the external clock is selected, the divide ratio is marked unused but keeps its stored value.

Top module: `vclk_cfg_bank`

## Requirements
- R1: After reset `fb_div_o` is 0x69D, `vco_band_o` is 01, `cp_code_o` is 001, `ext_clk_o` is 0 and `post_div_o` is 4. Reads return the revision byte at 0x00, 0x69 at 0x01, 0xD0 at 0x02 and 0x48 at 0x03.
- R2: Address 0x00 always reads the `REV_ID` parameter. A write to 0x00 changes nothing.
- R3: A write to 0x01 stages the upper eight divide bits and leaves `fb_div_o` unchanged. A later read of 0x01 returns the staged byte.
- R4: A write to 0x02 with a valid result loads `fb_div_o` with {staged 0x01 byte, wdata[7:4]} on the clock edge that takes the write. At that same edge `commit_o` rises for exactly one cycle.
- R5: A commit whose 12-bit result is 0 or 1 leaves `fb_div_o` unchanged and raises `reject_o` for one cycle instead of `commit_o`. The new nibble is still staged and reads back at 0x02 bits 7:4.
- R6: A write to 0x03 sets `vco_band_o` from bit 7:6, `cp_code_o` from bits 5:3 and `ext_clk_o` from bit 2. It takes effect on the edge that takes the write.
- R7: `post_div_o` is 8, 4, 2 or 1 for VCO band codes 00, 01, 10 or 11.
- R8: While `ext_clk_o` is 1, `fb_div_use_o` is 0. `fb_div_o` keeps its stored value through selecting and deselecting the external clock.
- R9: Unimplemented bits read as 0: 0x02 bits 3:0 and 0x03 bits 1:0. Addresses above 0x03 read 0x00 and ignore writes.
- R10: `rdata_o` is registered. It shows the addressed register on the cycle after `rd_en_i`, and it holds its value while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | One-cycle write strobe |
| rd_en_i | input | 1 | One-cycle read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Registered read data |
| fb_div_o | output | 12 | Active feedback divide ratio |
| fb_div_use_o | output | 1 | High when the clock path uses the divide ratio |
| vco_band_o | output | 2 | Active VCO band code |
| post_div_o | output | 4 | Post-divide factor decoded from the band |
| cp_code_o | output | 3 | Charge-pump current code |
| ext_clk_o | output | 1 | External pixel clock selected |
| commit_o | output | 1 | One-cycle pulse on an accepted divide commit |
| reject_o | output | 1 | One-cycle pulse on a refused divide commit |

## Verification
The assertions assume the front end never raises a write and a read strobe for conflicting work in a way the bank must arbitrate. Each strobe lasts one cycle and carries a stable address and data byte in that cycle, and inputs are at known values from the first edge after reset. The bench drives every strobe for exactly one cycle on the falling edge and then returns the strobes to 0. It never pulses a write and a read together, and it holds the strobes low through the reset period. Under these conditions the hold and no-change properties compare neighbouring cycles without seeing unknown inputs.

// File: rtl/vclk_cfg_pkg.sv
package vclk_cfg_pkg;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned DIV_W    = 12;
  localparam int unsigned DIV_LO_W = DIV_W - DATA_W;
  localparam int unsigned CP_W     = 3;
  localparam int unsigned BAND_W   = 2;
  localparam int unsigned PDIV_W   = 4;

  localparam int unsigned A_REV    = 0;
  localparam int unsigned A_DIV_HI = 1;
  localparam int unsigned A_DIV_LO = 2;
  localparam int unsigned A_CLKGEN = 3;

  localparam logic [DIV_W-1:0] DIV_RST = 12'h69D;
  localparam logic [DIV_W-1:0] DIV_MIN = 12'd2;

  typedef enum logic [BAND_W-1:0] {
    BAND_LOW  = 2'b00,
    BAND_MID  = 2'b01,
    BAND_HIGH = 2'b10,
    BAND_TOP  = 2'b11
  } vco_band_e;

  typedef struct packed {
    vco_band_e         band;
    logic [CP_W-1:0]   cp;
    logic              ext;
  } clkgen_cfg_t;

  localparam clkgen_cfg_t CLKGEN_RST = '{band: BAND_MID, cp: 3'b001, ext: 1'b0};

endpackage

// File: rtl/vclk_div_stage.sv
module vclk_div_stage
  import vclk_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   stg_hi_o,
  output logic [DIV_LO_W-1:0] stg_lo_o,
  output logic [DIV_W-1:0]    div_act_o,
  output logic                commit_o,
  output logic                reject_o
);

  logic [DATA_W-1:0]   stg_hi_q, stg_hi_d;
  logic [DIV_LO_W-1:0] stg_lo_q, stg_lo_d;
  logic [DIV_W-1:0]    act_q, act_d;
  logic                commit_q, commit_d;
  logic                reject_q, reject_d;
  logic                wr_hi, wr_lo, cand_ok;
  logic [DIV_W-1:0]    cand;

  always_comb begin
    wr_hi    = wr_en_i && (addr_i == ADDR_W'(A_DIV_HI));
    wr_lo    = wr_en_i && (addr_i == ADDR_W'(A_DIV_LO));
    cand     = {stg_hi_q, wdata_i[DATA_W-1 -: DIV_LO_W]};
    cand_ok  = (cand >= DIV_MIN);
    stg_hi_d = stg_hi_q;
    stg_lo_d = stg_lo_q;
    act_d    = act_q;
    commit_d = 1'b0;
    reject_d = 1'b0;
    if (wr_hi) begin
      stg_hi_d = wdata_i;
    end
    if (wr_lo) begin
      stg_lo_d = wdata_i[DATA_W-1 -: DIV_LO_W];
      if (cand_ok) begin
        act_d    = cand;
        commit_d = 1'b1;
      end else begin
        reject_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_hi_q <= DIV_RST[DIV_W-1 -: DATA_W];
      stg_lo_q <= DIV_RST[DIV_LO_W-1:0];
      act_q    <= DIV_RST;
      commit_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      stg_hi_q <= stg_hi_d;
      stg_lo_q <= stg_lo_d;
      act_q    <= act_d;
      commit_q <= commit_d;
      reject_q <= reject_d;
    end
  end

  assign stg_hi_o  = stg_hi_q;
  assign stg_lo_o  = stg_lo_q;
  assign div_act_o = act_q;
  assign commit_o  = commit_q;
  assign reject_o  = reject_q;

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q >= DIV_MIN); // R5
  AST_HI_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(A_DIV_HI)) |=> $stable(act_q)); // R3
  AST_COMMIT_MATCHES_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (act_q == {stg_hi_q, stg_lo_q})); // R4
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_q && reject_q)); // R4
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |-> $stable(act_q)); // R5
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_q && !$past(wr_en_i)) |-> 1'b0); // R4

endmodule

// File: rtl/vclk_clkgen_regs.sv
module vclk_clkgen_regs
  import vclk_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output clkgen_cfg_t       cfg_o,
  output logic [PDIV_W-1:0] post_div_o
);

  clkgen_cfg_t       cfg_q, cfg_d;
  logic              cfg_en;
  logic [PDIV_W-1:0] pdiv;

  always_comb begin
    cfg_en = wr_en_i && (addr_i == ADDR_W'(A_CLKGEN));
    cfg_d  = cfg_q;
    if (cfg_en) begin
      cfg_d.band = vco_band_e'(wdata_i[7:6]);
      cfg_d.cp   = wdata_i[5:3];
      cfg_d.ext  = wdata_i[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CLKGEN_RST;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // Lower band codes run the VCO faster than the pixel rate and divide down.
  always_comb begin
    unique case (cfg_q.band)
      BAND_LOW:  pdiv = 4'd8;
      BAND_MID:  pdiv = 4'd4;
      BAND_HIGH: pdiv = 4'd2;
      default:   pdiv = 4'd1;
    endcase
  end

  assign cfg_o      = cfg_q;
  assign post_div_o = pdiv;

  AST_POSTDIV_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(post_div_o) == 1); // R7
  AST_CLKGEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(A_CLKGEN)) |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/vclk_rd_port.sv
module vclk_rd_port
  import vclk_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [7:0]  REV_ID = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   stg_hi_i,
  input  logic [DIV_LO_W-1:0] stg_lo_i,
  input  clkgen_cfg_t         cfg_i,
  output logic [DATA_W-1:0]   rdata_o
);

  logic [DATA_W-1:0] mux, rd_q, rd_d;

  always_comb begin
    mux = '0;
    if (addr_i == ADDR_W'(A_REV))         mux = REV_ID;
    else if (addr_i == ADDR_W'(A_DIV_HI)) mux = stg_hi_i;
    else if (addr_i == ADDR_W'(A_DIV_LO)) mux = {stg_lo_i, {(DATA_W-DIV_LO_W){1'b0}}};
    else if (addr_i == ADDR_W'(A_CLKGEN)) mux = {cfg_i.band, cfg_i.cp, cfg_i.ext, 2'b00};
    rd_d = rd_en_i ? mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata_o = rd_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R10
  AST_REV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(A_REV)) |=> (rdata_o == REV_ID)); // R2
  AST_UNUSED_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(A_CLKGEN)) |=> (rdata_o[1:0] == 2'b00)); // R9

endmodule

// File: rtl/vclk_cfg_bank.sv
module vclk_cfg_bank
  import vclk_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [7:0]  REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [11:0]       fb_div_o,
  output logic              fb_div_use_o,
  output logic [1:0]        vco_band_o,
  output logic [3:0]        post_div_o,
  output logic [2:0]        cp_code_o,
  output logic              ext_clk_o,
  output logic              commit_o,
  output logic              reject_o
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [DATA_W-1:0]   stg_hi;
  logic [DIV_LO_W-1:0] stg_lo;
  logic [DIV_W-1:0]    div_act;
  clkgen_cfg_t         cfg;
  logic [PDIV_W-1:0]   pdiv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  vclk_div_stage #(.ADDR_W(ADDR_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .stg_hi_o  (stg_hi),
    .stg_lo_o  (stg_lo),
    .div_act_o (div_act),
    .commit_o  (commit_o),
    .reject_o  (reject_o)
  );

  vclk_clkgen_regs #(.ADDR_W(ADDR_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cfg_o      (cfg),
    .post_div_o (pdiv)
  );

  vclk_rd_port #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .stg_hi_i (stg_hi),
    .stg_lo_i (stg_lo),
    .cfg_i    (cfg),
    .rdata_o  (rdata_o)
  );

  assign fb_div_o     = div_act;
  assign fb_div_use_o = ~cfg.ext;
  assign vco_band_o   = cfg.band;
  assign post_div_o   = pdiv;
  assign cp_code_o    = cfg.cp;
  assign ext_clk_o    = cfg.ext;

  AST_EXT_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(ext_clk_o) || $fell(ext_clk_o)) |-> $stable(fb_div_o)); // R8
  AST_EXT_MASKS_USE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_clk_o |-> !fb_div_use_o); // R8

endmodule

// File: tb/vclk_cfg_bank_tb.sv
module vclk_cfg_bank_tb_top;

  localparam logic [7:0] REV = 8'h01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [11:0] fb_div;
  logic        fb_use;
  logic [1:0]  band;
  logic [3:0]  pdiv;
  logic [2:0]  cp;
  logic        ext;
  logic        commit;
  logic        reject;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #10 clk = ~clk;

  vclk_cfg_bank #(.ADDR_W(8), .REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .fb_div_o(fb_div), .fb_div_use_o(fb_use), .vco_band_o(band),
    .post_div_o(pdiv), .cp_code_o(cp), .ext_clk_o(ext),
    .commit_o(commit), .reject_o(reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Strobe held for one cycle; sampled on the falling edge after the capturing edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // {is_read, addr, data, expected}: write -> expected fb_div; read -> expected rdata
  localparam int NV = 16;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h12, 12'h69D},  // R3 stage only
    {1'b1, 8'h01, 8'h00, 12'h012},  // R3 staged read
    {1'b1, 8'h02, 8'h00, 12'h0D0},  // R9 low nibble zero
    {1'b0, 8'h02, 8'hA5, 12'h12A},  // R4 commit
    {1'b1, 8'h02, 8'h00, 12'h0A0},  // R9
    {1'b0, 8'h01, 8'hFF, 12'h12A},  // R3
    {1'b0, 8'h02, 8'hF0, 12'hFFF},  // R4 max
    {1'b0, 8'h01, 8'h00, 12'hFFF},  // R3
    {1'b0, 8'h02, 8'h10, 12'hFFF},  // R5 value 1 refused
    {1'b1, 8'h02, 8'h00, 12'h010},  // R5 nibble still staged
    {1'b0, 8'h02, 8'h20, 12'h002},  // R4 min
    {1'b0, 8'h00, 8'h55, 12'h002},  // R2 write ignored
    {1'b1, 8'h00, 8'h00, {4'h0, REV}}, // R2
    {1'b0, 8'h03, 8'hFF, 12'h002},  // R6
    {1'b1, 8'h03, 8'h00, 12'h0FC},  // R9 bits 1:0 zero
    {1'b0, 8'h07, 8'hAA, 12'h002}   // R9 write to hole
  };

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 fb_div", 32'(fb_div), 32'h69D);
    chk("R1 band", 32'(band), 32'h1);
    chk("R1 cp", 32'(cp), 32'h1);
    chk("R1 ext", 32'(ext), 32'h0);
    chk("R1 post_div", 32'(pdiv), 32'd4);
    chk("R1 use", 32'(fb_use), 32'h1);
    rd(8'h00); chk("R1 rd 0x00", 32'(rdata), 32'(REV));
    rd(8'h01); chk("R1 rd 0x01", 32'(rdata), 32'h69);
    rd(8'h02); chk("R1 rd 0x02", 32'(rdata), 32'hD0);
    rd(8'h03); chk("R1 rd 0x03", 32'(rdata), 32'h48);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        rd(VEC[i][27:20]);
        chk("vector rdata", 32'(rdata), 32'(VEC[i][7:0]));
      end else begin
        wr(VEC[i][27:20], VEC[i][19:12]);
        chk("vector fb_div", 32'(fb_div), 32'(VEC[i][11:0]));
      end
    end
    rd(8'h07); chk("R9 hole reads zero", 32'(rdata), 32'h0);

    // R7 band decode and R6 field placement
    wr(8'h03, 8'b00_101_0_00);
    chk("R7 band00", 32'(pdiv), 32'd8); chk("R6 cp", 32'(cp), 32'd5); chk("R6 band", 32'(band), 32'd0);
    wr(8'h03, 8'b01_010_0_00); chk("R7 band01", 32'(pdiv), 32'd4);
    wr(8'h03, 8'b10_000_0_00); chk("R7 band10", 32'(pdiv), 32'd2);
    wr(8'h03, 8'b11_111_0_00); chk("R7 band11", 32'(pdiv), 32'd1); chk("R6 cp7", 32'(cp), 32'd7);

    // R4 pulse timing
    wr(8'h01, 8'h40);
    chk("R4 no pulse on hi", 32'(commit), 32'h0);
    wr(8'h02, 8'h30);
    chk("R4 pulse", 32'(commit), 32'h1);
    chk("R4 value", 32'(fb_div), 32'h403);
    @(negedge clk); chk("R4 pulse one cycle", 32'(commit), 32'h0);

    // R5 zero refused
    wr(8'h01, 8'h00);
    wr(8'h02, 8'h00);
    chk("R5 reject", 32'(reject), 32'h1);
    chk("R5 no commit", 32'(commit), 32'h0);
    chk("R5 held", 32'(fb_div), 32'h403);
    @(negedge clk); chk("R5 reject one cycle", 32'(reject), 32'h0);

    // R8 external clock select
    wr(8'h03, 8'b01_001_1_00);
    chk("R8 ext", 32'(ext), 32'h1);
    chk("R8 use low", 32'(fb_use), 32'h0);
    chk("R8 div kept", 32'(fb_div), 32'h403);
    wr(8'h03, 8'b01_001_0_00);
    chk("R8 use back", 32'(fb_use), 32'h1);
    chk("R8 div kept after", 32'(fb_div), 32'h403);

    // R10 read data hold
    rd(8'h01);
    chk("R10 read", 32'(rdata), 32'h00);
    @(negedge clk); addr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 hold", 32'(rdata), 32'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule